// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Boot Preloader

This block runs once after power-on reset and copies a small configuration image from an optional two-wire serial EEPROM into the chip's configuration registers. When reset is released it checks the level on the SCL pin to decide whether a ROM is fitted. If a ROM is present, it addresses the ROM and reads a fixed 32-byte image starting at offset zero. It then issues one register write per byte. Each write carries the received byte ANDed with a per-address write mask, together with the mask itself, so the register file changes only the bits it allows to be preloaded.

A ROM that has never been programmed reads as all ones. The block therefore treats 0xFF in the first image byte as a blank ROM: it stops the read at that byte and writes nothing. If the ROM fails to acknowledge any of the addressing bytes, the block releases the bus with a STOP, raises an error flag and also writes nothing. An indicator output stays on from reset until the preload has ended, whichever way it ends. The bus clock is divided down from the system clock, and every SCL cycle is built from four equal phases.

Top module: `eeprom_boot_loader`

## Requirements
- R1: If `scl_sense_i` is low in the first clock after reset is released, no bus cycle is issued. `done_o` rises within two clocks, `err_o` stays low and no register is written.
- R2: `led_o` is high during reset and during the whole preload. It falls in the same cycle that `done_o` rises and stays low afterwards.
- R3: With a ROM present, the transfer opens with a START, the write slave address 0xA0 and the offset byte 0x00. A repeated START and the read slave address 0xA1 follow.
- R4: After the read address, 32 bytes are read in sequence. The block ACKs bytes 0 to 30, NACKs byte 31 and then issues a STOP.
- R5: Each image byte k produces exactly one write pulse, with addresses in ascending order. `cfg_addr_o` is k, `cfg_mask_o` is bits 8k+7..8k of `WR_MASK`, and `cfg_data_o` is the byte ANDed with that mask. With the default `WR_MASK`, the mask for k mod 4 = 0, 1, 2, 3 is 0xFF, 0x0F, 0xFF, 0x7F.
- R6: If byte 0 reads as 0xFF, the block NACKs it, issues a STOP and writes no register, with `err_o` low. Any other value in byte 0, including 0xFE, and 0xFF in any later byte are loaded normally.
- R7: If the ROM fails to ACK the write address, the offset or the read address, the block issues a STOP right after that acknowledge slot. It sends no further START, sets `err_o` and `done_o`, and writes no register.
- R8: SDA changes while SCL is high only to form a START or a STOP. Whenever `busy_o` is low, SCL is high and SDA is released.
- R9: `done_o` and `err_o` hold their values until the next reset. `busy_o` is high only while a bus transfer is in progress and never together with `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| scl_sense_i | input | 1 | Level on the SCL pin; high means a ROM is fitted |
| scl_o | output | 1 | Serial clock to the ROM |
| sda_i | input | 1 | Level on the SDA pin |
| sda_oe_o | output | 1 | Pulls SDA low when 1; SDA is released when 0 |
| cfg_we_o | output | 1 | One-cycle register write strobe |
| cfg_addr_o | output | $clog2(NBYTES) | Target register byte index |
| cfg_data_o | output | 8 | Image byte ANDed with the write mask |
| cfg_mask_o | output | 8 | Writable-bit mask for the target byte |
| busy_o | output | 1 | Bus transfer in progress |
| done_o | output | 1 | Preload has ended |
| err_o | output | 1 | ROM failed to acknowledge an addressing byte |
| led_o | output | 1 | Indicator that stays on until preload ends |

## Verification
Two decisions fall in the same cycle as the completion of byte 0: whether to issue the register write and whether to abort for a blank ROM. A second pair shares the completion of byte 31: its write and the choice of NACK over ACK. The bench provokes both by loading the ROM model with 0xFF in byte 0, then with 0xFE in byte 0 and 0xFF in byte 31. It judges the result from the scoreboard, which must see zero writes in the first case and all 32 in the second. It also uses the acknowledge counts seen by the ROM model: exactly one NACK, and it must fall after the first byte in the blank case and after the last byte otherwise.

// File: rtl/eeprom_boot_pkg.sv
package eeprom_boot_pkg;

    typedef enum logic [2:0] {
        ST_SENSE,
        ST_START,
        ST_TXBIT,
        ST_RXACK,
        ST_RXBIT,
        ST_TXACK,
        ST_STOP,
        ST_DONE
    } boot_state_e;

    typedef enum logic [1:0] {
        STG_WADDR,
        STG_OFFSET,
        STG_RADDR
    } boot_stage_e;

    localparam logic [7:0] DEV_ADDR_WR = 8'hA0;
    localparam logic [7:0] DEV_ADDR_RD = 8'hA1;
    localparam logic [7:0] IMG_OFFSET  = 8'h00;
    localparam logic [7:0] BLANK_BYTE  = 8'hFF;

endpackage

// File: rtl/boot_tick_gen.sv
module boot_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == CW'(DIV - 1));
        cnt_d = cnt_q;
        if (!en || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/boot_wmask_sel.sv
module boot_wmask_sel #(
    parameter int                     NBYTES  = 32,
    parameter int                     AW      = 5,
    parameter logic [8*NBYTES-1:0]    WR_MASK = '1
) (
    input  logic [AW-1:0] idx,
    output logic [7:0]    mask
);
    logic [AW+2:0] bit_base;

    always_comb begin
        bit_base = {idx, 3'b000};
        mask     = WR_MASK[bit_base +: 8];
    end
endmodule

// File: rtl/eeprom_boot_loader.sv
module eeprom_boot_loader
    import eeprom_boot_pkg::*;
#(
    parameter int                  NBYTES  = 32,
    parameter int                  CLK_DIV = 4,
    parameter logic [8*NBYTES-1:0] WR_MASK = {8{32'h7FFF_0FFF}},
    localparam int                 AW      = $clog2(NBYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_sense_i,
    output logic          scl_o,
    input  logic          sda_i,
    output logic          sda_oe_o,
    output logic          cfg_we_o,
    output logic [AW-1:0] cfg_addr_o,
    output logic [7:0]    cfg_data_o,
    output logic [7:0]    cfg_mask_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          err_o,
    output logic          led_o
);
    localparam logic [AW-1:0] LAST_IDX = AW'(NBYTES - 1);

    typedef struct packed {
        boot_state_e  st;
        boot_stage_e  stg;
        logic [1:0]   ph;
        logic [2:0]   bitn;
        logic [7:0]   sh;
        logic [AW-1:0] idx;
        logic         ack_ok;
        logic         nack_out;
        logic         scl;
        logic         sda_oe;
        logic         we;
        logic [AW-1:0] waddr;
        logic [7:0]   wdata;
        logic [7:0]   wmask;
        logic         err;
        logic         led;
    } boot_regs_t;

    localparam boot_regs_t REGS_RST = '{
        st:       ST_SENSE,
        stg:      STG_WADDR,
        ph:       2'd0,
        bitn:     3'd0,
        sh:       8'h00,
        idx:      '0,
        ack_ok:   1'b0,
        nack_out: 1'b0,
        scl:      1'b1,
        sda_oe:   1'b0,
        we:       1'b0,
        waddr:    '0,
        wdata:    8'h00,
        wmask:    8'h00,
        err:      1'b0,
        led:      1'b1
    };

    boot_regs_t r_d, r_q;
    logic       on_bus;
    logic       tick;
    logic [7:0] cur_mask;

    assign on_bus = (r_q.st != ST_SENSE) && (r_q.st != ST_DONE);

    boot_tick_gen #(
        .DIV (CLK_DIV)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (on_bus),
        .tick  (tick)
    );

    boot_wmask_sel #(
        .NBYTES  (NBYTES),
        .AW      (AW),
        .WR_MASK (WR_MASK)
    ) u_mask (
        .idx  (r_q.idx),
        .mask (cur_mask)
    );

    always_comb begin
        logic [1:0] np;
        r_d    = r_q;
        r_d.we = 1'b0;
        np     = r_q.ph + 2'd1;

        case (r_q.st)
            ST_SENSE: begin
                if (scl_sense_i) begin
                    r_d.st  = ST_START;
                    r_d.stg = STG_WADDR;
                    r_d.ph  = 2'd0;
                    r_d.scl = 1'b0;
                end else begin
                    r_d.st  = ST_DONE;
                    r_d.led = 1'b0;
                end
            end

            ST_DONE: begin
                r_d = r_q;
                r_d.we = 1'b0;
            end

            default: begin
                if (tick && (r_q.ph != 2'd3)) begin
                    // step inside one bus symbol
                    r_d.ph = np;
                    if (np == 2'd1) begin
                        case (r_q.st)
                            ST_TXBIT: r_d.sda_oe = ~r_q.sh[7];
                            ST_TXACK: r_d.sda_oe = ~r_q.nack_out;
                            ST_STOP:  r_d.sda_oe = 1'b1;
                            default:  r_d.sda_oe = 1'b0;
                        endcase
                    end else if (np == 2'd2) begin
                        r_d.scl = 1'b1;
                    end else begin
                        case (r_q.st)
                            ST_START: r_d.sda_oe = 1'b1;
                            ST_STOP:  r_d.sda_oe = 1'b0;
                            ST_RXACK: r_d.ack_ok = ~sda_i;
                            ST_RXBIT: r_d.sh     = {r_q.sh[6:0], sda_i};
                            default:  r_d.sda_oe = r_q.sda_oe;
                        endcase
                    end
                end else if (tick) begin
                    // symbol boundary: choose the next symbol
                    r_d.ph  = 2'd0;
                    r_d.scl = 1'b0;
                    case (r_q.st)
                        ST_START: begin
                            r_d.st   = ST_TXBIT;
                            r_d.bitn = 3'd0;
                            r_d.sh   = (r_q.stg == STG_RADDR) ? DEV_ADDR_RD : DEV_ADDR_WR;
                        end
                        ST_TXBIT: begin
                            if (r_q.bitn == 3'd7) begin
                                r_d.st = ST_RXACK;
                            end else begin
                                r_d.bitn = r_q.bitn + 3'd1;
                                r_d.sh   = {r_q.sh[6:0], 1'b0};
                            end
                        end
                        ST_RXACK: begin
                            if (!r_q.ack_ok) begin
                                r_d.err = 1'b1;
                                r_d.st  = ST_STOP;
                            end else begin
                                case (r_q.stg)
                                    STG_WADDR: begin
                                        r_d.stg  = STG_OFFSET;
                                        r_d.st   = ST_TXBIT;
                                        r_d.bitn = 3'd0;
                                        r_d.sh   = IMG_OFFSET;
                                    end
                                    STG_OFFSET: begin
                                        r_d.stg = STG_RADDR;
                                        r_d.st  = ST_START;
                                    end
                                    default: begin
                                        r_d.st   = ST_RXBIT;
                                        r_d.bitn = 3'd0;
                                        r_d.idx  = '0;
                                    end
                                endcase
                            end
                        end
                        ST_RXBIT: begin
                            if (r_q.bitn != 3'd7) begin
                                r_d.bitn = r_q.bitn + 3'd1;
                            end else begin
                                r_d.st = ST_TXACK;
                                if ((r_q.idx == '0) && (r_q.sh == BLANK_BYTE)) begin
                                    r_d.nack_out = 1'b1;
                                end else begin
                                    r_d.we       = 1'b1;
                                    r_d.waddr    = r_q.idx;
                                    r_d.wdata    = r_q.sh & cur_mask;
                                    r_d.wmask    = cur_mask;
                                    r_d.nack_out = (r_q.idx == LAST_IDX);
                                end
                            end
                        end
                        ST_TXACK: begin
                            if (r_q.nack_out) begin
                                r_d.st = ST_STOP;
                            end else begin
                                r_d.idx  = r_q.idx + AW'(1);
                                r_d.st   = ST_RXBIT;
                                r_d.bitn = 3'd0;
                            end
                        end
                        default: begin
                            // end of STOP: bus left idle
                            r_d.st  = ST_DONE;
                            r_d.scl = 1'b1;
                            r_d.led = 1'b0;
                        end
                    endcase
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= REGS_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign scl_o      = r_q.scl;
    assign sda_oe_o   = r_q.sda_oe;
    assign cfg_we_o   = r_q.we;
    assign cfg_addr_o = r_q.waddr;
    assign cfg_data_o = r_q.wdata;
    assign cfg_mask_o = r_q.wmask;
    assign busy_o     = on_bus;
    assign done_o     = (r_q.st == ST_DONE);
    assign err_o      = r_q.err;
    assign led_o      = r_q.led;

endmodule

// File: rtl/eeprom_boot_loader_chk.sv
module eeprom_boot_loader_chk #(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_o,
    input logic          sda_oe_o,
    input logic          cfg_we_o,
    input logic [AW-1:0] cfg_addr_o,
    input logic          busy_o,
    input logic          done_o,
    input logic          err_o,
    input logic          led_o
);
    logic [AW:0] wr_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_cnt <= '0;
        end else if (cfg_we_o) begin
            wr_cnt <= wr_cnt + (AW+1)'(1);
        end
    end

    a_r5_write_order: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we_o |-> (cfg_addr_o == wr_cnt[AW-1:0]));

    a_r5_write_on_bus: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we_o |-> busy_o);

    a_r7_err_no_writes: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (wr_cnt == '0));

    a_r8_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (scl_o && !sda_oe_o));

    a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> done_o);

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    a_r2_led_off_when_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !led_o);

    a_r2_led_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> led_o);
endmodule

bind eeprom_boot_loader eeprom_boot_loader_chk #(
    .AW (AW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_o      (scl_o),
    .sda_oe_o   (sda_oe_o),
    .cfg_we_o   (cfg_we_o),
    .cfg_addr_o (cfg_addr_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .led_o      (led_o)
);

// File: tb/eeprom_boot_loader_test.sv
module eeprom_boot_loader_test;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 32;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_sense = 1'b1;
    logic       scl_o, sda_oe_o, cfg_we_o, busy_o, done_o, err_o, led_o;
    logic [4:0] cfg_addr_o;
    logic [7:0] cfg_data_o, cfg_mask_o;
    logic       slv_low = 1'b0;
    wire        sda_line = ~sda_oe_o & ~slv_low;

    always #(CLK_PERIOD/2) clk = ~clk;

    eeprom_boot_loader uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_sense_i (scl_sense),
        .scl_o       (scl_o),
        .sda_i       (sda_line),
        .sda_oe_o    (sda_oe_o),
        .cfg_we_o    (cfg_we_o),
        .cfg_addr_o  (cfg_addr_o),
        .cfg_data_o  (cfg_data_o),
        .cfg_mask_o  (cfg_mask_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .err_o       (err_o),
        .led_o       (led_o)
    );

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    string cur_req = "R5";

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mask_of(input int k);
        case (k % 4)
            0: return 8'hFF;
            1: return 8'h0F;
            2: return 8'hFF;
            default: return 8'h7F;
        endcase
    endfunction

    // ROM model
    logic [7:0] mem [NB];
    int   nack_at = -1;
    bit   act, first_fall, rxm, sl_ack, mack, p_scl, p_m;
    int   bitn, rcv_n, ptr, starts, stops, macks, mnacks, sent_n, last_nack_byte;
    logic [7:0] sh;
    logic [7:0] rcv [4];

    always @(negedge clk) begin
        if (!rst_n) begin
            act = 0; first_fall = 0; rxm = 1; sl_ack = 0; mack = 0;
            bitn = 0; rcv_n = 0; ptr = 0; starts = 0; stops = 0;
            macks = 0; mnacks = 0; sent_n = 0; last_nack_byte = -1;
            slv_low = 1'b0; p_scl = 1; p_m = 1; sh = 8'h00;
        end else begin
            if (scl_o && p_scl && p_m && sda_oe_o) begin
                starts++; act = 1; first_fall = 1; rxm = 1; bitn = 0; slv_low = 1'b0;
            end else if (scl_o && p_scl && !p_m && !sda_oe_o) begin
                stops++; act = 0; slv_low = 1'b0;
            end else if (act && scl_o && !p_scl) begin
                if (rxm && bitn < 8) sh = {sh[6:0], sda_line};
                if (!rxm && bitn == 8) begin
                    mack = ~sda_line;
                    if (mack) macks++;
                    else begin mnacks++; last_nack_byte = sent_n - 1; end
                end
            end else if (act && !scl_o && p_scl) begin
                if (first_fall) first_fall = 0;
                else if (rxm) begin
                    if (bitn < 7) bitn++;
                    else if (bitn == 7) begin
                        if (rcv_n < 4) rcv[rcv_n] = sh;
                        sl_ack = (rcv_n != nack_at);
                        if (rcv_n == 1) ptr = int'(sh) % NB;
                        rcv_n++;
                        slv_low = sl_ack;
                        bitn = 8;
                    end else begin
                        slv_low = 1'b0; bitn = 0;
                        if (sl_ack && sh[0]) begin
                            rxm = 0; sent_n++; slv_low = ~mem[ptr][7];
                        end
                    end
                end else begin
                    if (bitn < 7) begin bitn++; slv_low = ~mem[ptr][7-bitn]; end
                    else if (bitn == 7) begin bitn = 8; slv_low = 1'b0; end
                    else if (mack) begin
                        ptr = (ptr + 1) % NB; bitn = 0; sent_n++; slv_low = ~mem[ptr][7];
                    end else begin
                        slv_low = 1'b0; act = 0;
                    end
                end
            end
            p_scl = scl_o; p_m = ~sda_oe_o;
        end
    end

    // scoreboard
    typedef struct { logic [4:0] a; logic [7:0] d; logic [7:0] m; } wr_t;
    wr_t expq [$];
    int  wr_seen;

    task automatic push_image();
        for (int k = 0; k < NB; k++) begin
            wr_t e;
            e.a = 5'(k); e.m = mask_of(k); e.d = mem[k] & mask_of(k);
            expq.push_back(e);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && cfg_we_o) begin
            wr_seen++;
            if (expq.size() == 0) begin
                chk(0, cur_req, "unexpected write at", int'(cfg_addr_o), -1);
            end else begin
                wr_t e;
                e = expq.pop_front();
                chk(cfg_addr_o == e.a, "R5", "write address", int'(cfg_addr_o), int'(e.a));
                chk(cfg_data_o == e.d, "R5", "write data", int'(cfg_data_o), int'(e.d));
                chk(cfg_mask_o == e.m, "R5", "write mask", int'(cfg_mask_o), int'(e.m));
            end
        end
    end

    task automatic start_run(input bit sense, input int nack);
        rst_n = 1'b0;
        scl_sense = sense;
        nack_at = nack;
        wr_seen = 0;
        expq.delete();
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_done();
        int n;
        n = 0;
        @(negedge clk);
        rst_n = 1'b1;
        while (!done_o && n < 20000) begin
            @(negedge clk);
            n++;
        end
        repeat (20) @(negedge clk);
    endtask

    task automatic check_end(input string req, input bit exp_err, input int exp_starts,
                             input int exp_wr);
        chk(done_o == 1'b1, "R9", "done", int'(done_o), 1);
        chk(busy_o == 1'b0, "R9", "busy after end", int'(busy_o), 0);
        chk(err_o == exp_err, req, "err flag", int'(err_o), int'(exp_err));
        chk(led_o == 1'b0, "R2", "indicator after end", int'(led_o), 0);
        chk(starts == exp_starts, req, "START count", starts, exp_starts);
        chk(stops == ((exp_starts > 0) ? 1 : 0), "R8", "STOP count", stops,
            (exp_starts > 0) ? 1 : 0);
        chk(wr_seen == exp_wr, req, "write count", wr_seen, exp_wr);
        chk(expq.size() == 0, req, "writes left in scoreboard", expq.size(), 0);
        chk(scl_o && !sda_oe_o, "R8", "bus idle", int'({scl_o, sda_oe_o}), 2);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        // scenario A: no ROM fitted
        start_run(1'b0, -1);
        chk(scl_o == 1'b1, "R8", "reset scl", int'(scl_o), 1);
        chk(sda_oe_o == 1'b0, "R8", "reset sda", int'(sda_oe_o), 0);
        chk(led_o == 1'b1, "R2", "reset indicator", int'(led_o), 1);
        chk({busy_o, done_o, err_o, cfg_we_o} == 4'b0, "R9", "reset flags",
            int'({busy_o, done_o, err_o, cfg_we_o}), 0);
        cur_req = "R1";
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(done_o == 1'b1, "R1", "done soon without ROM", int'(done_o), 1);
        repeat (30) @(negedge clk);
        check_end("R1", 1'b0, 0, 0);

        // scenario B: normal image
        start_run(1'b1, -1);
        for (int k = 0; k < NB; k++) mem[k] = 8'(k * 37 + 11);
        push_image();
        cur_req = "R5";
        @(negedge clk);
        rst_n = 1'b1;
        repeat (300) @(negedge clk);
        chk(led_o == 1'b1 && busy_o == 1'b1, "R2", "indicator mid-load",
            int'({led_o, busy_o}), 3);
        begin
            int n;
            n = 0;
            while (!done_o && n < 20000) begin @(negedge clk); n++; end
        end
        repeat (20) @(negedge clk);
        check_end("R4", 1'b0, 2, NB);
        chk(rcv[0] == 8'hA0, "R3", "write address byte", int'(rcv[0]), 'hA0);
        chk(rcv[1] == 8'h00, "R3", "offset byte", int'(rcv[1]), 0);
        chk(rcv[2] == 8'hA1, "R3", "read address byte", int'(rcv[2]), 'hA1);
        chk(macks == NB - 1, "R4", "ACK count", macks, NB - 1);
        chk(mnacks == 1 && last_nack_byte == NB - 1, "R4", "NACK on last byte",
            last_nack_byte, NB - 1);

        // scenario C: blank ROM
        start_run(1'b1, -1);
        for (int k = 0; k < NB; k++) mem[k] = 8'hFF;
        cur_req = "R6";
        wait_done();
        check_end("R6", 1'b0, 2, 0);
        chk(mnacks == 1 && macks == 0 && last_nack_byte == 0, "R6", "NACK on byte 0",
            last_nack_byte, 0);

        // scenario D: first byte 0xFE, last byte 0xFF
        start_run(1'b1, -1);
        for (int k = 0; k < NB; k++) mem[k] = 8'(k * 53 + 1);
        mem[0] = 8'hFE;
        mem[NB-1] = 8'hFF;
        push_image();
        cur_req = "R6";
        wait_done();
        check_end("R6", 1'b0, 2, NB);

        // scenarios E/F/G: ROM does not acknowledge an addressing byte
        for (int i = 0; i < 3; i++) begin
            start_run(1'b1, i);
            for (int k = 0; k < NB; k++) mem[k] = 8'(k + 1);
            cur_req = "R7";
            wait_done();
            check_end("R7", 1'b1, (i == 2) ? 2 : 1, 0);
            chk(rcv_n == i + 1, "R7", "bytes sent before abort", rcv_n, i + 1);
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule